// File: doc/BRIEF.md
# Focus Acquisition Controller

This block acquires focus on an optical disc drive. On a start command it drives the focus actuator with a triangular search ramp. The ramp is an up/down counter that runs between a programmable low limit and a programmable high limit, and an increasing ramp moves the lens toward the disc. While it sweeps, the block watches two digital inputs: an RF-present flag and the sign of the focus error. It closes the focus loop in the first cycle in which the lens moves toward the disc, RF is present and the focus error changes sign.

Once the loop is closed, the ramp word is frozen. A settle timer runs for a fixed number of cycles and then samples RF-present once. If RF is present at that instant, the loop stays closed. If it is absent, a failure flag is raised so that protection logic can react. A search that sweeps through a programmable number of full periods without closing ends in a timeout. A stop command returns the block to idle from any state. The equalizer and the PWM stage that follow the ramp word are outside this block.

The controller has six states:
- `FS_IDLE`: stopped.
- `FS_SEARCH`: ramping.
- `FS_SETTLE`: closed and waiting for the check.
- `FS_LOCKED`: closed and confirmed.
- `FS_FAILED`: the check found no RF.
- `FS_TIMEOUT`: the search gave up.

Its transitions are:
- start: `FS_IDLE`, `FS_TIMEOUT` or `FS_FAILED` to `FS_SEARCH`.
- close: `FS_SEARCH` to `FS_SETTLE`.
- give-up: `FS_SEARCH` to `FS_TIMEOUT`.
- confirm: `FS_SETTLE` to `FS_LOCKED`.
- reject: `FS_SETTLE` to `FS_FAILED`.
- stop: any state to `FS_IDLE`.

Top module: `focus_acq_ctrl`

## Requirements
- R1: After reset the block is idle. `ramp_o` equals midscale (2^(RAMP_W-1)), and `search_o`, `loop_closed_o`, `timeout_o` and `fail_o` are all 0.
- R2: A `start_i` pulse accepted in idle causes the next cycle to show `ramp_o` equal to `lo_lim_i`, with `search_o` = 1 and the direction toward the disc (`toward_disc_o` = 1).
- R3: While searching, the ramp moves by `step_i` every cycle. When moving up, a step that would reach or pass `hi_lim_i` lands exactly on `hi_lim_i` and reverses the direction. When moving down, a step that would reach or pass `lo_lim_i` lands exactly on `lo_lim_i` and reverses the direction. `toward_disc_o` = 1 means the ramp is increasing. The limits must satisfy `lo_lim_i` < `hi_lim_i`, and `step_i` must be nonzero.
- R4: A focus-error zero crossing is a cycle in which `fe_neg_i` differs from its value in the previous cycle. A steady `fe_neg_i` level is never a crossing.
- R5: The loop closes only when direction up, `rf_ok_i` = 1 and a zero crossing occur in the same cycle. In the next cycle `search_o` falls to 0 and `loop_closed_o` = 1, and `ramp_o` then holds the value it had in the closing cycle. A crossing while the ramp moves down, or with `rf_ok_i` = 0, does not close the loop.
- R6: Closing starts a window of SETTLE_CYC cycles. In the last cycle of that window `rf_ok_i` is sampled, and its value in the earlier cycles of the window has no effect. If the sample is 1, the loop stays closed. If it is 0, then from the next cycle `fail_o` = 1, `loop_closed_o` = 0 and `ramp_o` is at midscale.
- R7: Each reversal at the low limit completes one search period. The reversal that completes period number `max_periods_i` (a value of 0 is treated as 1) ends the search instead of reversing. From the next cycle `timeout_o` = 1, `search_o` = 0 and `ramp_o` is at midscale.
- R8: `stop_i` in any state returns the block to idle on the next cycle, with midscale output and all status flags at 0. `stop_i` takes precedence over `start_i` and over closing.
- R9: `start_i` has no effect while the block is searching, settling or locked.
- R10: `start_i` in the timeout or failed state clears that flag and begins a new search exactly as described in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a focus search (one-cycle pulse) |
| stop_i | input | 1 | Abort and return to idle |
| step_i | input | RAMP_W | Ramp increment per cycle |
| lo_lim_i | input | RAMP_W | Lower ramp limit |
| hi_lim_i | input | RAMP_W | Upper ramp limit |
| max_periods_i | input | PER_W | Search periods allowed before timeout |
| rf_ok_i | input | 1 | RF signal present |
| fe_neg_i | input | 1 | Sign of the focus error (1 = negative) |
| ramp_o | output | RAMP_W | Focus actuator drive word |
| toward_disc_o | output | 1 | Ramp is currently increasing |
| search_o | output | 1 | Search in progress status |
| loop_closed_o | output | 1 | Focus loop closed |
| timeout_o | output | 1 | Search ended without closure |
| fail_o | output | 1 | RF absent at the post-close check |

## Verification
The bench builds the block with an 8-bit ramp and SETTLE_CYC = 16, and uses limits 40 and 100 with a step of 8. A full search period therefore takes 16 cycles, and a two-period timeout, the whole settle window and both outcomes of the RF check all fall within a few dozen cycles. The step does not divide the span evenly, so both clamp-and-reverse edges are exercised. Crossings are placed on the downward slope, under absent RF and on the upward slope, so that each of the three closing conditions is shown to be necessary.

// File: rtl/focus_acq_pkg.sv
package focus_acq_pkg;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_SEARCH,
        FS_SETTLE,
        FS_LOCKED,
        FS_FAILED,
        FS_TIMEOUT
    } fs_state_e;

endpackage

// File: rtl/focus_ramp_gen.sv
module focus_ramp_gen #(
    parameter int RAMP_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              park_i,
    input  logic              seed_i,
    input  logic              run_i,
    input  logic [RAMP_W-1:0] lo_i,
    input  logic [RAMP_W-1:0] hi_i,
    input  logic [RAMP_W-1:0] step_i,
    output logic [RAMP_W-1:0] ramp_o,
    output logic              up_o,
    output logic              low_turn_o
);

    localparam logic [RAMP_W-1:0] MID = {1'b1, {(RAMP_W-1){1'b0}}};

    logic [RAMP_W-1:0] ramp_q;
    logic              up_q;
    logic              hit_hi;
    logic              hit_lo;

    // A step that reaches or passes a limit lands exactly on that limit.
    always_comb begin
        hit_hi = (ramp_q >= hi_i) || ((hi_i - ramp_q) <= step_i);
        hit_lo = (ramp_q <= lo_i) || ((ramp_q - lo_i) <= step_i);
    end

    assign low_turn_o = !up_q && hit_lo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ramp_q <= MID;
            up_q   <= 1'b1;
        end else if (park_i) begin
            ramp_q <= MID;
            up_q   <= 1'b1;
        end else if (seed_i) begin
            ramp_q <= lo_i;
            up_q   <= 1'b1;
        end else if (run_i) begin
            if (up_q) begin
                if (hit_hi) begin
                    ramp_q <= hi_i;
                    up_q   <= 1'b0;
                end else begin
                    ramp_q <= ramp_q + step_i;
                end
            end else begin
                if (hit_lo) begin
                    ramp_q <= lo_i;
                    up_q   <= 1'b1;
                end else begin
                    ramp_q <= ramp_q - step_i;
                end
            end
        end
    end

    assign ramp_o = ramp_q;
    assign up_o   = up_q;

    AST_RAMP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $past(run_i) && $stable(lo_i) && $stable(hi_i))
            |-> (ramp_q >= lo_i && ramp_q <= hi_i)); // R3

endmodule

// File: rtl/focus_zc_detect.sv
module focus_zc_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic fe_neg_i,
    output logic zc_o
);

    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= fe_neg_i;
    end

    assign zc_o = fe_neg_i ^ prev_q;

endmodule

// File: rtl/focus_settle_timer.sv
module focus_settle_timer #(
    parameter int SETTLE_CYC = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic en_i,
    output logic done_o
);

    localparam int          CW   = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (clear_i)              cnt_q <= '0;
        else if (en_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign done_o = en_i && (cnt_q == LAST);

    AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |-> cnt_q <= LAST); // R6

endmodule

// File: rtl/focus_acq_ctrl.sv
module focus_acq_ctrl
    import focus_acq_pkg::*;
#(
    parameter int RAMP_W     = 10,
    parameter int PER_W      = 8,
    parameter int SETTLE_CYC = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [RAMP_W-1:0] step_i,
    input  logic [RAMP_W-1:0] lo_lim_i,
    input  logic [RAMP_W-1:0] hi_lim_i,
    input  logic [PER_W-1:0]  max_periods_i,
    input  logic              rf_ok_i,
    input  logic              fe_neg_i,
    output logic [RAMP_W-1:0] ramp_o,
    output logic              toward_disc_o,
    output logic              search_o,
    output logic              loop_closed_o,
    output logic              timeout_o,
    output logic              fail_o
);

    localparam logic [RAMP_W-1:0] MID = {1'b1, {(RAMP_W-1){1'b0}}};
    localparam logic [PER_W:0]    ONE = {{PER_W{1'b0}}, 1'b1};

    fs_state_e state_q, state_d;

    logic             zc;
    logic             low_turn;
    logic             settle_done;
    logic             close_hit;
    logic             give_up;
    logic             park, seed, run;
    logic             settle_clr;
    logic [PER_W-1:0] per_cnt_q;

    focus_zc_detect u_zc (
        .clk      (clk),
        .rst_n    (rst_n),
        .fe_neg_i (fe_neg_i),
        .zc_o     (zc)
    );

    focus_ramp_gen #(.RAMP_W(RAMP_W)) u_ramp (
        .clk        (clk),
        .rst_n      (rst_n),
        .park_i     (park),
        .seed_i     (seed),
        .run_i      (run),
        .lo_i       (lo_lim_i),
        .hi_i       (hi_lim_i),
        .step_i     (step_i),
        .ramp_o     (ramp_o),
        .up_o       (toward_disc_o),
        .low_turn_o (low_turn)
    );

    focus_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (settle_clr),
        .en_i    (state_q == FS_SETTLE),
        .done_o  (settle_done)
    );

    // Transition conditions
    assign close_hit = toward_disc_o && rf_ok_i && zc;
    assign give_up   = low_turn &&
                       (({1'b0, per_cnt_q} + ONE) >= {1'b0, max_periods_i});

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_i) begin
            state_d = FS_IDLE;
        end else begin
            unique case (state_q)
                FS_IDLE, FS_TIMEOUT, FS_FAILED: begin
                    if (start_i) state_d = FS_SEARCH;
                end
                FS_SEARCH: begin
                    if (close_hit)    state_d = FS_SETTLE;
                    else if (give_up) state_d = FS_TIMEOUT;
                end
                FS_SETTLE: begin
                    if (settle_done) state_d = rf_ok_i ? FS_LOCKED : FS_FAILED;
                end
                FS_LOCKED: state_d = FS_LOCKED;
                default:   state_d = FS_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FS_IDLE;
        else        state_q <= state_d;
    end

    // Datapath control derived from the transition being taken
    always_comb begin
        park       = (state_d != state_q) &&
                     (state_d == FS_IDLE || state_d == FS_TIMEOUT || state_d == FS_FAILED);
        seed       = (state_q != FS_SEARCH) && (state_d == FS_SEARCH);
        run        = (state_q == FS_SEARCH) && (state_d == FS_SEARCH);
        settle_clr = (state_q != FS_SETTLE) && (state_d == FS_SETTLE);
    end

    // Completed search periods
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                per_cnt_q <= '0;
        else if (seed)             per_cnt_q <= '0;
        else if (run && low_turn)  per_cnt_q <= per_cnt_q + 1'b1;
    end

    // Moore status outputs
    always_comb begin
        search_o      = 1'b0;
        loop_closed_o = 1'b0;
        timeout_o     = 1'b0;
        fail_o        = 1'b0;
        unique case (state_q)
            FS_IDLE:    ;
            FS_SEARCH:  search_o      = 1'b1;
            FS_SETTLE:  loop_closed_o = 1'b1;
            FS_LOCKED:  loop_closed_o = 1'b1;
            FS_FAILED:  fail_o        = 1'b1;
            FS_TIMEOUT: timeout_o     = 1'b1;
            default:    ;
        endcase
    end

    AST_CLOSE_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loop_closed_o) |-> $past(toward_disc_o && rf_ok_i && (fe_neg_i != $past(fe_neg_i)))); // R5

    AST_RAMP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_closed_o && $past(loop_closed_o)) |-> $stable(ramp_o)); // R5

    AST_STATUS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(search_o) |-> (loop_closed_o || timeout_o || $past(stop_i))); // R5

    AST_FAIL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_o) |-> (!$past(rf_ok_i) && ramp_o == MID)); // R6

    AST_TIMEOUT_AT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> $past(search_o && !toward_disc_o)); // R7

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (ramp_o == MID && !search_o && !loop_closed_o && !timeout_o && !fail_o)); // R8

    AST_ONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({search_o, loop_closed_o, timeout_o, fail_o}) <= 1); // R1

endmodule

// File: tb/focus_acq_ctrl_tb.sv
module focus_acq_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int RW   = 8;
    localparam int LO   = 40;
    localparam int HI   = 100;
    localparam int STEP = 8;
    localparam int SETTLE = 16;
    localparam logic [RW-1:0] MIDV = 8'd128;

    localparam logic [3:0] F_IDLE = 4'b0000;
    localparam logic [3:0] F_SRCH = 4'b1000;
    localparam logic [3:0] F_CLSD = 4'b0100;
    localparam logic [3:0] F_TOUT = 4'b0010;
    localparam logic [3:0] F_FAIL = 4'b0001;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          stop_i = 1'b0;
    logic [RW-1:0] step_i = RW'(STEP);
    logic [RW-1:0] lo_lim_i = RW'(LO);
    logic [RW-1:0] hi_lim_i = RW'(HI);
    logic [7:0]    max_periods_i = 8'd2;
    logic          rf_ok_i = 1'b0;
    logic          fe_neg_i = 1'b0;
    logic [RW-1:0] ramp_o;
    logic          toward_disc_o, search_o, loop_closed_o, timeout_o, fail_o;

    int cyc = 0;
    int base = 0;
    int n_checks = 0;
    int n_fail = 0;

    int         q_cyc[$];
    logic [7:0] q_ramp[$];
    logic [3:0] q_flg[$];
    string      q_tag[$];

    focus_acq_ctrl #(.RAMP_W(RW), .PER_W(8), .SETTLE_CYC(SETTLE)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .stop_i        (stop_i),
        .step_i        (step_i),
        .lo_lim_i      (lo_lim_i),
        .hi_lim_i      (hi_lim_i),
        .max_periods_i (max_periods_i),
        .rf_ok_i       (rf_ok_i),
        .fe_neg_i      (fe_neg_i),
        .ramp_o        (ramp_o),
        .toward_disc_o (toward_disc_o),
        .search_o      (search_o),
        .loop_closed_o (loop_closed_o),
        .timeout_o     (timeout_o),
        .fail_o        (fail_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Triangle value expected i cycles after a search begins (R3)
    function automatic logic [7:0] tri_at(int i);
        int v = LO;
        bit up = 1'b1;
        for (int k = 0; k < i; k++) begin
            if (up) begin
                if (v + STEP >= HI) begin v = HI; up = 1'b0; end
                else v = v + STEP;
            end else begin
                if (v - STEP <= LO) begin v = LO; up = 1'b1; end
                else v = v - STEP;
            end
        end
        return 8'(v);
    endfunction

    task automatic push(int c, logic [7:0] r, logic [3:0] f, string tag);
        q_cyc.push_back(c);
        q_ramp.push_back(r);
        q_flg.push_back(f);
        q_tag.push_back(tag);
    endtask

    task automatic push_tri(int from_i, int to_i, string tag);
        for (int i = from_i; i <= to_i; i++) push(base + i, tri_at(i), F_SRCH, tag);
    endtask

    task automatic push_hold(int from_i, int to_i, logic [7:0] r, logic [3:0] f, string tag);
        for (int i = from_i; i <= to_i; i++) push(base + i, r, f, tag);
    endtask

    task automatic go_to(int idx);
        while (cyc < base + idx) @(negedge clk);
    endtask

    // Monitor: pops expected items when their cycle comes up
    always @(negedge clk) begin
        while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
            logic [3:0] act;
            act = {search_o, loop_closed_o, timeout_o, fail_o};
            n_checks++;
            if (q_cyc[0] != cyc) begin
                n_fail++;
                $display("FAIL %s: item for cycle %0d missed (now %0d)", q_tag[0], q_cyc[0], cyc);
            end else if (ramp_o !== q_ramp[0] || act !== q_flg[0]) begin
                n_fail++;
                $display("FAIL %s @%0d: ramp=%0d flags=%b expected ramp=%0d flags=%b",
                         q_tag[0], cyc, ramp_o, act, q_ramp[0], q_flg[0]);
            end
            void'(q_cyc.pop_front());
            void'(q_ramp.pop_front());
            void'(q_flg.pop_front());
            void'(q_tag.pop_front());
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 5000) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", n_checks + 1, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        base = cyc + 1;
        push_hold(0, 1, MIDV, F_IDLE, "R1 reset idle");
        go_to(2);

        // Timeout after two periods; start ignored mid-search
        max_periods_i = 8'd2;
        rf_ok_i = 1'b0;
        start_i = 1'b1;
        base = cyc + 1;
        push(base, 8'(LO), F_SRCH, "R2 start loads low limit");
        push_tri(1, 31, "R3 triangle ramp");
        push_hold(32, 34, MIDV, F_TOUT, "R7 timeout");
        @(negedge clk) start_i = 1'b0;
        go_to(5);
        start_i = 1'b1;               // R9: ignored while searching
        @(negedge clk) start_i = 1'b0;
        go_to(35);

        // Restart from timeout, then closing conditions
        max_periods_i = 8'd50;
        rf_ok_i = 1'b1;
        start_i = 1'b1;
        base = cyc + 1;
        push(base, 8'(LO), F_SRCH, "R10 restart clears timeout");
        push_tri(1, 20, "R4 R5 no premature close");
        @(negedge clk) start_i = 1'b0;
        go_to(10);
        fe_neg_i = ~fe_neg_i;         // R5: crossing on downward slope
        go_to(18);
        rf_ok_i = 1'b0;
        fe_neg_i = ~fe_neg_i;         // R5: crossing without RF
        go_to(19);
        rf_ok_i = 1'b1;               // R4: steady level, no crossing
        go_to(20);
        fe_neg_i = ~fe_neg_i;         // all three conditions
        push_hold(21, 41, tri_at(20), F_CLSD, "R5 R6 close and lock");
        go_to(22);
        rf_ok_i = 1'b0;               // R6: ignored before the check
        go_to(27);
        rf_ok_i = 1'b1;
        go_to(39);
        start_i = 1'b1;               // R9: ignored while locked
        @(negedge clk) start_i = 1'b0;
        go_to(42);

        // Stop from locked
        stop_i = 1'b1;
        base = cyc + 1;
        push_hold(0, 1, MIDV, F_IDLE, "R8 stop to idle");
        @(negedge clk) stop_i = 1'b0;
        go_to(2);

        // Post-close RF check fails
        rf_ok_i = 1'b1;
        start_i = 1'b1;
        base = cyc + 1;
        push_tri(0, 2, "R2 search again");
        @(negedge clk) start_i = 1'b0;
        go_to(2);
        fe_neg_i = ~fe_neg_i;
        push_hold(3, 3 + SETTLE - 1, tri_at(2), F_CLSD, "R5 closed during settle");
        push_hold(3 + SETTLE, 3 + SETTLE + 1, MIDV, F_FAIL, "R6 RF absent at check");
        go_to(4);
        rf_ok_i = 1'b0;
        go_to(3 + SETTLE + 2);

        // Restart from failed, then stop during search
        rf_ok_i = 1'b0;
        start_i = 1'b1;
        base = cyc + 1;
        push(base, 8'(LO), F_SRCH, "R10 restart clears fail");
        push_tri(1, 3, "R3 ramp after restart");
        push(base + 4, MIDV, F_IDLE, "R8 stop during search");
        @(negedge clk) start_i = 1'b0;
        go_to(3);
        stop_i = 1'b1;
        @(negedge clk) stop_i = 1'b0;
        go_to(6);

        while (q_cyc.size() > 0) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule